// File: doc/BRIEF.md
# Remote Terminal Status Word Control

This block keeps the flag bits of a serial-bus remote terminal's status word and builds the 16-bit word that the terminal returns after each command. The flags come from discrete inputs driven by the attached subsystem and from events inside the terminal. These events are a handshake failure, a reset-terminal mode command and a new-command indication. The subsystem can raise a service request, report a fault, accept dynamic bus control, flag the terminal, and force the message-error bit for a command it judges illegal. It can force that bit only during a short window after the command is announced.

Two status registers are kept. The current register is rebuilt on every clock. The last register captures the current one whenever a status response goes out. Some mode commands must answer with the previous status word, so a select input picks which register drives the status output. An optional flag-control group lets the subsystem load its own values for the subsystem-flag and terminal-flag bits in place of the default rules. When that group is disabled, its inputs have no effect.

Top module: `rt_status_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cur_status`, `last_status`, `status_word` and `dbc_grant` become zero, and the fault, message-error and flag-override state are cleared.
- R2: The status word holds the terminal address in bits 15:11, message error in bit 10, service request in bit 8, subsystem flag in bit 2, bus-control acceptance in bit 1 and terminal flag in bit 0. Bits 9 and 7:3 are always zero.
- R3: Bit 8 of `cur_status` equals the inverse of `srq_n` sampled at the previous clock edge, and has no other effect.
- R4: A low `sserr_n` or a high `hs_fail` at a clock edge sets a sticky fault. While the flag-control group is not overriding, the subsystem-flag bit shows the fault from that same edge onward.
- R5: The fault clears only on reset, or on `mode_stb` with `mode_code` equal to 5'b01000. Other codes leave it set. If a set condition is present in the same cycle, the set wins.
- R6: Bit 1 of `cur_status` is the inverse of `dbc_acc_n` from the previous edge. `dbc_grant` pulses high one cycle after `dbc_cmd` only when `dbc_acc_n` is low; otherwise it stays low.
- R7: A falling edge of `newcmd_n` clears the message-error bit and opens a window of WIN_CYC = CLK_MHZ*WIN_NS/1000 clock edges (50 by default). A rising edge of `merr_req` sampled at edge k = 1..WIN_CYC after the falling edge sets bit 10.
- R8: A rising edge of `merr_req` sampled at edge WIN_CYC+1 or later after the falling edge, or with no window open, leaves bit 10 clear.
- R9: A high `resp_stb` at an edge copies `cur_status` into `last_status`. Otherwise `last_status` holds. `status_word` shows `last_status` while `last_sel` is high and `cur_status` while it is low.
- R10: With `flag_ctl_en_n` low, `flag_load` loads `nxt_ssf`/`nxt_tf` into an override register, and `flag_src_sel` high makes bits 2 and 0 show that register. With `flag_ctl_en_n` high, `flag_src_sel` and `flag_load` have no effect and the register is not loaded.
- R11: With no override active, bit 0 of `cur_status` is the inverse of `tflag_n` from the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| rt_addr | input | 5 | Terminal address |
| srq_n | input | 1 | Service request, active low |
| sserr_n | input | 1 | Subsystem error, active low |
| hs_fail | input | 1 | Handshake failure pulse |
| tflag_n | input | 1 | Terminal flag request, active low |
| dbc_acc_n | input | 1 | Dynamic bus control accept, active low |
| dbc_cmd | input | 1 | Bus-control mode command received pulse |
| dbc_grant | output | 1 | Bus-control request pulse to subsystem |
| mode_stb | input | 1 | Legal mode command strobe |
| mode_code | input | 5 | Mode code of that command |
| newcmd_n | input | 1 | New-command indication, active low |
| merr_req | input | 1 | Message-error force request |
| flag_ctl_en_n | input | 1 | Flag-control group enable, active low |
| flag_src_sel | input | 1 | Show override flags instead of default rules |
| nxt_ssf | input | 1 | Next subsystem-flag value |
| nxt_tf | input | 1 | Next terminal-flag value |
| flag_load | input | 1 | Load the next-flag values |
| resp_stb | input | 1 | Status response sent pulse |
| last_sel | input | 1 | Return the last status word |
| cur_status | output | 16 | Current status register |
| last_status | output | 16 | Last status register |
| status_word | output | 16 | Selected status word |

## Verification
The bench places message-error requests at the first and last edges of the window and at one edge past it. A counter that is off by one would accept the late request or drop the boundary one. Before each boundary request it checks that the new command cleared the bit. It sends a non-reset mode code and a reset code while the error input is still low, so a design that clears on any mode command, or lets the clear beat the set, loses the flag. It drives the option inputs while the group is disabled and then enables it without a fresh load, so a design that loads the override register regardless of the enable shows stale flags.

// File: rtl/rt_sw_pkg.sv
// Package: shared widths, status-word bit positions and the word packer
// for the remote terminal status control block.
// Assumes a 16-bit status word with a 5-bit address field at the top.
package rt_sw_pkg;

    localparam int ADDR_W   = 5;
    localparam int SW_W     = 16;
    localparam int MC_W     = 5;

    // Bit positions inside the status word (bus-standard placement).
    localparam int POS_ME   = 10;
    localparam int POS_INST = 9;
    localparam int POS_SR   = 8;
    localparam int POS_SSF  = 2;
    localparam int POS_DBCA = 1;
    localparam int POS_TF   = 0;

    // Mode code that resets the terminal.
    localparam logic [MC_W-1:0] MC_RESET_TERM = 5'b01000;

    // Flag bits that feed one status word.
    typedef struct packed {
        logic me;
        logic sr;
        logic ssf;
        logic dbca;
        logic tf;
    } sw_flags_t;

    // Place the address and the flags; every other bit stays zero.
    function automatic logic [SW_W-1:0] sw_pack(input logic [ADDR_W-1:0] addr,
                                                input sw_flags_t        f);
        logic [SW_W-1:0] w;
        w                     = '0;
        w[SW_W-1 -: ADDR_W]   = addr;
        w[POS_ME]             = f.me;
        w[POS_SR]             = f.sr;
        w[POS_SSF]            = f.ssf;
        w[POS_DBCA]           = f.dbca;
        w[POS_TF]             = f.tf;
        return w;
    endfunction

endpackage

// File: rtl/rt_sw_fault_track.sv
// Sticky subsystem-fault tracker.
// Sets on a low subsystem-error level or a handshake-failure pulse and
// clears only on reset or a reset-terminal mode command; set wins.
// Assumes all inputs are synchronous to clk.
module rt_sw_fault_track
    import rt_sw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sserr_n,
    input  logic            hs_fail,
    input  logic            mode_stb,
    input  logic [MC_W-1:0] mode_code,
    output logic            fault_d,
    output logic            fault_q
);

    logic set_req;
    logic clr_req;

    // Decode the set and clear conditions for this cycle.
    always_comb begin
        set_req = !sserr_n || hs_fail;
        clr_req = mode_stb && (mode_code == MC_RESET_TERM);
    end

    // Next fault value: a set request overrides a clear request.
    always_comb begin
        if (set_req) begin
            fault_d = 1'b1;
        end else if (clr_req) begin
            fault_d = 1'b0;
        end else begin
            fault_d = fault_q;
        end
    end

    // Hold the fault condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= fault_d;
        end
    end

endmodule

// File: rtl/rt_sw_merr_window.sv
// Message-error force window.
// A falling edge of the new-command indication clears the message-error
// flag and opens a window of WIN_CYC clock edges; a rising edge of the
// force request seen inside the window sets the flag.
// Assumes newcmd_n and merr_req are synchronous to clk.
module rt_sw_merr_window #(
    parameter int WIN_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic newcmd_n,
    input  logic merr_req,
    output logic me_d,
    output logic me_q,
    output logic win_open
);

    localparam int CNT_W = (WIN_CYC < 1) ? 1 : $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC);

    logic             nc_q;
    logic             mr_q;
    logic             cmd_fall;
    logic             req_rise;
    logic [CNT_W-1:0] win_cnt;
    logic [CNT_W-1:0] win_cnt_d;

    // Edge detection on the command and request inputs.
    always_comb begin
        cmd_fall = nc_q && !newcmd_n;
        req_rise = merr_req && !mr_q;
        win_open = (win_cnt != '0);
    end

    // Window counter: reload on a new command, count down to zero.
    always_comb begin
        if (cmd_fall) begin
            win_cnt_d = CNT_LOAD;
        end else if (win_open) begin
            win_cnt_d = win_cnt - 1'b1;
        end else begin
            win_cnt_d = win_cnt;
        end
    end

    // Next message-error flag: cleared by a new command, set inside window.
    always_comb begin
        if (cmd_fall) begin
            me_d = 1'b0;
        end else if (req_rise && win_open) begin
            me_d = 1'b1;
        end else begin
            me_d = me_q;
        end
    end

    // Register edge history, window count and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nc_q    <= 1'b1;
            mr_q    <= 1'b1;
            win_cnt <= '0;
            me_q    <= 1'b0;
        end else begin
            nc_q    <= newcmd_n;
            mr_q    <= merr_req;
            win_cnt <= win_cnt_d;
            me_q    <= me_d;
        end
    end

endmodule

// File: rtl/rt_sw_flag_option.sv
// Optional flag control for the subsystem-flag and terminal-flag bits.
// With the group enabled (en_n low) the subsystem can load override
// values and select them; with it disabled the option inputs do nothing
// and the default rules apply.
// Assumes all inputs are synchronous to clk.
module rt_sw_flag_option (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    input  logic src_sel,
    input  logic nxt_ssf,
    input  logic nxt_tf,
    input  logic load,
    input  logic fault_d,
    input  logic tflag_n,
    output logic ssf_sel,
    output logic tf_sel
);

    logic ovr_ssf_q;
    logic ovr_tf_q;
    logic ovr_ssf_d;
    logic ovr_tf_d;
    logic use_ovr;

    // Next override contents: load only while the group is enabled.
    always_comb begin
        if (!en_n && load) begin
            ovr_ssf_d = nxt_ssf;
            ovr_tf_d  = nxt_tf;
        end else begin
            ovr_ssf_d = ovr_ssf_q;
            ovr_tf_d  = ovr_tf_q;
        end
    end

    // Choose between override values and the default flag rules.
    always_comb begin
        use_ovr = !en_n && src_sel;
        ssf_sel = use_ovr ? ovr_ssf_d : fault_d;
        tf_sel  = use_ovr ? ovr_tf_d  : !tflag_n;
    end

    // Hold the override register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_ssf_q <= 1'b0;
            ovr_tf_q  <= 1'b0;
        end else begin
            ovr_ssf_q <= ovr_ssf_d;
            ovr_tf_q  <= ovr_tf_d;
        end
    end

endmodule

// File: rtl/rt_status_ctrl.sv
// Remote terminal status word control (top).
// Builds the current status register each clock from the subsystem
// discretes and the fault, message-error and flag-option submodules,
// copies it to the last status register on each response, and selects
// which of the two drives the status output.
// Assumes synchronous inputs and a clock of CLK_MHZ megahertz.
module rt_status_ctrl
    import rt_sw_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int WIN_NS  = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              srq_n,
    input  logic              sserr_n,
    input  logic              hs_fail,
    input  logic              tflag_n,
    input  logic              dbc_acc_n,
    input  logic              dbc_cmd,
    output logic              dbc_grant,
    input  logic              mode_stb,
    input  logic [MC_W-1:0]   mode_code,
    input  logic              newcmd_n,
    input  logic              merr_req,
    input  logic              flag_ctl_en_n,
    input  logic              flag_src_sel,
    input  logic              nxt_ssf,
    input  logic              nxt_tf,
    input  logic              flag_load,
    input  logic              resp_stb,
    input  logic              last_sel,
    output logic [SW_W-1:0]   cur_status,
    output logic [SW_W-1:0]   last_status,
    output logic [SW_W-1:0]   status_word
);

    localparam int WIN_CYC = (CLK_MHZ * WIN_NS) / 1000;

    logic            fault_d;
    logic            fault_q;
    logic            me_d;
    logic            me_q;
    logic            win_open;
    logic            ssf_sel;
    logic            tf_sel;
    sw_flags_t       flags_d;
    logic [SW_W-1:0] cur_d;

    rt_sw_fault_track u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .sserr_n   (sserr_n),
        .hs_fail   (hs_fail),
        .mode_stb  (mode_stb),
        .mode_code (mode_code),
        .fault_d   (fault_d),
        .fault_q   (fault_q)
    );

    rt_sw_merr_window #(
        .WIN_CYC (WIN_CYC)
    ) u_merr (
        .clk      (clk),
        .rst_n    (rst_n),
        .newcmd_n (newcmd_n),
        .merr_req (merr_req),
        .me_d     (me_d),
        .me_q     (me_q),
        .win_open (win_open)
    );

    rt_sw_flag_option u_opt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_n    (flag_ctl_en_n),
        .src_sel (flag_src_sel),
        .nxt_ssf (nxt_ssf),
        .nxt_tf  (nxt_tf),
        .load    (flag_load),
        .fault_d (fault_d),
        .tflag_n (tflag_n),
        .ssf_sel (ssf_sel),
        .tf_sel  (tf_sel)
    );

    // Gather the next flag values and pack the next current status word.
    always_comb begin
        flags_d.me   = me_d;
        flags_d.sr   = !srq_n;
        flags_d.ssf  = ssf_sel;
        flags_d.dbca = !dbc_acc_n;
        flags_d.tf   = tf_sel;
        cur_d        = sw_pack(rt_addr, flags_d);
    end

    // Current and last status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_status  <= '0;
            last_status <= '0;
        end else begin
            cur_status  <= cur_d;
            if (resp_stb) begin
                last_status <= cur_status;
            end
        end
    end

    // Bus-control request pulse, gated by the accept input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbc_grant <= 1'b0;
        end else begin
            dbc_grant <= dbc_cmd && !dbc_acc_n;
        end
    end

    // Select the word returned on the bus.
    always_comb begin
        status_word = last_sel ? last_status : cur_status;
    end

endmodule

// File: rtl/rt_sw_checker.sv
// Assertion checker for rt_status_ctrl, attached with bind below.
// Relates ports and submodule state over time.
module rt_sw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  rt_addr,
    input logic        srq_n,
    input logic        sserr_n,
    input logic        hs_fail,
    input logic        dbc_acc_n,
    input logic        dbc_cmd,
    input logic        dbc_grant,
    input logic        mode_stb,
    input logic [4:0]  mode_code,
    input logic        flag_ctl_en_n,
    input logic        resp_stb,
    input logic [15:0] cur_status,
    input logic [15:0] last_status,
    input logic        fault_q,
    input logic        me_q,
    input logic        win_open
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (cur_status == 16'h0 && last_status == 16'h0 && !dbc_grant)); // R1

    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_status[9] == 1'b0 && cur_status[7:3] == 5'b0)); // R2

    AST_ADDR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cur_status[15:11] == $past(rt_addr)); // R2

    AST_SR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cur_status[8] == $past(!srq_n)); // R3

    AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && (!sserr_n || hs_fail)) |-> fault_q); // R4

    AST_SSF_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && flag_ctl_en_n && (!sserr_n || hs_fail)) |-> cur_status[2]); // R4

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fault_q) && !$past(mode_stb && mode_code == 5'b01000)) |-> fault_q); // R5

    AST_DBCA_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cur_status[1] == $past(!dbc_acc_n)); // R6

    AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dbc_grant |-> $past(dbc_cmd && !dbc_acc_n)); // R6

    AST_ME_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(me_q)) |-> $past(win_open)); // R8

    AST_LAST_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(resp_stb)) |-> last_status == $past(cur_status)); // R9

    AST_LAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(resp_stb)) |-> $stable(last_status)); // R9

endmodule

bind rt_status_ctrl rt_sw_checker i_rt_sw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rt_addr       (rt_addr),
    .srq_n         (srq_n),
    .sserr_n       (sserr_n),
    .hs_fail       (hs_fail),
    .dbc_acc_n     (dbc_acc_n),
    .dbc_cmd       (dbc_cmd),
    .dbc_grant     (dbc_grant),
    .mode_stb      (mode_stb),
    .mode_code     (mode_code),
    .flag_ctl_en_n (flag_ctl_en_n),
    .resp_stb      (resp_stb),
    .cur_status    (cur_status),
    .last_status   (last_status),
    .fault_q       (fault_q),
    .me_q          (me_q),
    .win_open      (win_open)
);

// File: tb/test_rt_status_ctrl.sv
// Directed bench for rt_status_ctrl: one task per scenario, each checking
// its own results. Inputs change on the falling clock edge; outputs are
// sampled on the falling edge after the rising edge that updates them.
module test_rt_status_ctrl;

    localparam int WIN = 50;  // 100 MHz * 500 ns

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rt_addr;
    logic        srq_n, sserr_n, hs_fail, tflag_n, dbc_acc_n, dbc_cmd;
    logic        dbc_grant;
    logic        mode_stb;
    logic [4:0]  mode_code;
    logic        newcmd_n, merr_req;
    logic        flag_ctl_en_n, flag_src_sel, nxt_ssf, nxt_tf, flag_load;
    logic        resp_stb, last_sel;
    logic [15:0] cur_status, last_status, status_word;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rt_status_ctrl i_rt_status_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .rt_addr       (rt_addr),
        .srq_n         (srq_n),
        .sserr_n       (sserr_n),
        .hs_fail       (hs_fail),
        .tflag_n       (tflag_n),
        .dbc_acc_n     (dbc_acc_n),
        .dbc_cmd       (dbc_cmd),
        .dbc_grant     (dbc_grant),
        .mode_stb      (mode_stb),
        .mode_code     (mode_code),
        .newcmd_n      (newcmd_n),
        .merr_req      (merr_req),
        .flag_ctl_en_n (flag_ctl_en_n),
        .flag_src_sel  (flag_src_sel),
        .nxt_ssf       (nxt_ssf),
        .nxt_tf        (nxt_tf),
        .flag_load     (flag_load),
        .resp_stb      (resp_stb),
        .last_sel      (last_sel),
        .cur_status    (cur_status),
        .last_status   (last_status),
        .status_word   (status_word)
    );

    // Expected word from the bit layout of R2.
    function automatic logic [15:0] exp_sw(input logic [4:0] a, input logic me, input logic sr,
                                           input logic ssf, input logic dbca, input logic tf);
        return {a, me, 1'b0, sr, 5'b00000, ssf, dbca, tf};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        srq_n = 1'b1; sserr_n = 1'b1; hs_fail = 1'b0; tflag_n = 1'b1;
        dbc_acc_n = 1'b1; dbc_cmd = 1'b0; mode_stb = 1'b0; mode_code = 5'b0;
        newcmd_n = 1'b1; merr_req = 1'b0; flag_ctl_en_n = 1'b1; flag_src_sel = 1'b0;
        nxt_ssf = 1'b0; nxt_tf = 1'b0; flag_load = 1'b0; resp_stb = 1'b0; last_sel = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        rt_addr = 5'b10110;
        idle_inputs();
        srq_n = 1'b0; dbc_acc_n = 1'b0; dbc_cmd = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 cur", cur_status, 16'h0);
        chk("R1 last", last_status, 16'h0);
        chk("R1 word", status_word, 16'h0);
        chk("R1 grant", {15'b0, dbc_grant}, 16'h0);
        idle_inputs();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_layout();
        chk("R2 idle", cur_status, exp_sw(5'b10110, 0, 0, 0, 0, 0));
        rt_addr = 5'b01001;
        srq_n = 1'b0; dbc_acc_n = 1'b0; tflag_n = 1'b0;
        @(negedge clk);
        chk("R2 flags", cur_status, exp_sw(5'b01001, 0, 1, 0, 1, 1));
        idle_inputs();
        rt_addr = 5'b10110;
        @(negedge clk);
        chk("R2 back", cur_status, exp_sw(5'b10110, 0, 0, 0, 0, 0));
    endtask

    task automatic t_srq();
        srq_n = 1'b0;
        @(negedge clk);
        chk("R3 set", cur_status, exp_sw(rt_addr, 0, 1, 0, 0, 0));
        srq_n = 1'b1;
        @(negedge clk);
        chk("R3 clear", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
    endtask

    task automatic t_fault();
        hs_fail = 1'b1;
        @(negedge clk);
        hs_fail = 1'b0;
        chk("R4 handshake", cur_status, exp_sw(rt_addr, 0, 0, 1, 0, 0));
        repeat (3) @(negedge clk);
        chk("R4 sticky", cur_status, exp_sw(rt_addr, 0, 0, 1, 0, 0));
        mode_stb = 1'b1; mode_code = 5'b00111;
        @(negedge clk);
        mode_stb = 1'b0;
        chk("R5 other code", cur_status, exp_sw(rt_addr, 0, 0, 1, 0, 0));
        mode_stb = 1'b1; mode_code = 5'b01000;
        @(negedge clk);
        mode_stb = 1'b0;
        chk("R5 reset code", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
        sserr_n = 1'b0;
        @(negedge clk);
        chk("R4 sserr", cur_status, exp_sw(rt_addr, 0, 0, 1, 0, 0));
        mode_stb = 1'b1;
        @(negedge clk);
        mode_stb = 1'b0;
        chk("R5 set wins", cur_status, exp_sw(rt_addr, 0, 0, 1, 0, 0));
        sserr_n = 1'b1;
        @(negedge clk);
        chk("R4 held", cur_status, exp_sw(rt_addr, 0, 0, 1, 0, 0));
        mode_stb = 1'b1;
        @(negedge clk);
        mode_stb = 1'b0; mode_code = 5'b0;
        chk("R5 cleared", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
    endtask

    task automatic t_dbc();
        dbc_cmd = 1'b1;
        @(negedge clk);
        dbc_cmd = 1'b0;
        chk("R6 inhibited", {15'b0, dbc_grant}, 16'h0);
        chk("R6 bit clear", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
        dbc_acc_n = 1'b0; dbc_cmd = 1'b1;
        @(negedge clk);
        dbc_cmd = 1'b0;
        chk("R6 grant", {15'b0, dbc_grant}, 16'h1);
        chk("R6 bit set", cur_status, exp_sw(rt_addr, 0, 0, 0, 1, 0));
        @(negedge clk);
        chk("R6 pulse", {15'b0, dbc_grant}, 16'h0);
        dbc_acc_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_last();
        srq_n = 1'b0;
        @(negedge clk);
        resp_stb = 1'b1;
        @(negedge clk);
        resp_stb = 1'b0;
        chk("R9 copy", last_status, exp_sw(rt_addr, 0, 1, 0, 0, 0));
        srq_n = 1'b1;
        @(negedge clk);
        chk("R9 cur moves", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
        chk("R9 last holds", last_status, exp_sw(rt_addr, 0, 1, 0, 0, 0));
        last_sel = 1'b1;
        #1;
        chk("R9 select last", status_word, exp_sw(rt_addr, 0, 1, 0, 0, 0));
        last_sel = 1'b0;
        #1;
        chk("R9 select cur", status_word, exp_sw(rt_addr, 0, 0, 0, 0, 0));
        @(negedge clk);
    endtask

    task automatic t_option();
        flag_ctl_en_n = 1'b1; flag_src_sel = 1'b1; nxt_ssf = 1'b1; nxt_tf = 1'b1; flag_load = 1'b1;
        @(negedge clk);
        flag_load = 1'b0;
        chk("R10 disabled", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
        flag_ctl_en_n = 1'b0;
        @(negedge clk);
        chk("R10 no load", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
        flag_load = 1'b1;
        @(negedge clk);
        flag_load = 1'b0;
        chk("R10 override", cur_status, exp_sw(rt_addr, 0, 0, 1, 0, 1));
        flag_src_sel = 1'b0;
        @(negedge clk);
        chk("R10 default sel", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
        flag_ctl_en_n = 1'b1; flag_src_sel = 1'b1;
        @(negedge clk);
        chk("R10 disabled sel", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
        idle_inputs();
        @(negedge clk);
    endtask

    task automatic t_tflag();
        tflag_n = 1'b0;
        @(negedge clk);
        chk("R11 set", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 1));
        tflag_n = 1'b1;
        @(negedge clk);
        chk("R11 clear", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
    endtask

    // Request sampled at edge k after the new-command falling edge.
    task automatic merr_case(input int k, input logic exp_me, input string req);
        newcmd_n = 1'b1; merr_req = 1'b0;
        @(negedge clk);
        newcmd_n = 1'b0;
        @(negedge clk);
        chk("R7 cleared by command", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
        for (int i = 1; i < k; i++) @(negedge clk);
        merr_req = 1'b1;
        @(negedge clk);
        chk(req, cur_status, exp_sw(rt_addr, exp_me, 0, 0, 0, 0));
        merr_req = 1'b0;
        newcmd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_merr();
        merr_case(1, 1'b1, "R7 first edge");
        merr_case(WIN, 1'b1, "R7 last edge");
        merr_case(WIN + 1, 1'b0, "R8 late");
        merr_req = 1'b1;
        @(negedge clk);
        merr_req = 1'b0;
        chk("R8 no window", cur_status, exp_sw(rt_addr, 0, 0, 0, 0, 0));
    endtask

    initial begin
        t_reset();
        t_layout();
        t_srq();
        t_fault();
        t_dbc();
        t_last();
        t_option();
        t_tflag();
        t_merr();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule